// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Selection Unit

This unit takes two single-precision operands and an 8-bit control byte and returns one of eight minimum or maximum results. The eight variants come from three independent choices: minimum or maximum, signed or magnitude comparison, and whether a NaN input propagates or yields to a number. A separate two-bit sign policy then decides the sign bit of whatever value was chosen.

The result does not depend on operand order in the cases where a plain compare-and-select would. Negative zero orders below positive zero. A magnitude tie between operands of opposite sign falls back to signed order. Every NaN that reaches the output is quiet. Field widths are parameters, so the same block serves other binary formats. By default the result and its valid flag are registered, one cycle after the request.

Top module: `fp_minmax_unit`

## Requirements
- R1: The operation field is ctrl_imm[2:0]. Bit 0 set selects maximum and clear selects minimum. Bit 1 set compares magnitudes and clear compares signed values. Bit 2 set selects the number forms and clear selects the propagating forms. When no NaN is involved, the result magnitude is that of op_a or op_b.
- R2: The sign policy is ctrl_imm[4:3]. 00 takes the sign of op_a, 01 keeps the chosen value's sign, 10 forces the sign to 0 and 11 forces it to 1. The policy applies to every result, NaN results included.
- R3: In signed ordering, -0 (0x80000000) is less than +0 (0x00000000). Minimum returns -0 and maximum returns +0, whatever the operand order.
- R4: In the propagating forms (ctrl_imm[2]=0), a NaN on either input gives a NaN output. That output is op_a with fraction bit 22 set if op_a is a NaN, and otherwise op_b with fraction bit 22 set.
- R5: In the number forms (ctrl_imm[2]=1), if exactly one input is a NaN, the other input is returned unchanged before the sign policy. If both are NaN, the result is op_a with fraction bit 22 set.
- R6: The magnitude forms compare the operands with their sign bits cleared. On a magnitude tie between operands of opposite sign, they use signed order, so the minimum is the negative operand.
- R7: When both operands are equal in the active ordering, op_a is returned.
- R8: result and out_valid update one clock after in_valid is sampled high. out_valid is low after a cycle with in_valid low, and result holds its value through such a cycle. Reset clears both to zero.
- R9: ctrl_imm[7:5] has no effect on the result.
- R10: Infinities order as the extremes: -inf is below every finite value and +inf is above every finite value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request valid |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| ctrl_imm | input | 8 | Operation and sign policy control |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Selected value |

## Verification
Every ordered pair is drawn from thirteen values: both zeros, ±1, ±1.5, ±inf, the largest finite value, a denormal, a quiet NaN and two signalling NaNs. Each pair is applied under all eight operations and all four sign policies.

The zero pairs separate signed-zero ordering from plain equality. The ±1 and ±1.5 pairs separate magnitude from signed comparison and exercise the opposite-sign magnitude tie. Mixing NaN with numbers separates the propagating forms from the number forms and shows which payload is kept. A second pass sets the unused control bits to show they change nothing, and valid-low gaps check that the result holds.

// File: rtl/minmax_pkg.sv
package minmax_pkg;

   typedef enum logic [1:0] {
      SGN_FROM_A = 2'b00,
      SGN_KEEP   = 2'b01,
      SGN_CLEAR  = 2'b10,
      SGN_SET    = 2'b11
   } sign_pol_e;

   typedef struct packed {
      logic num_form;
      logic use_mag;
      logic is_max;
   } op_sel_t;

endpackage

// File: rtl/minmax_classify.sv
module minmax_classify #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int W = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0] x,
   output logic         is_nan,
   output logic [W-1:0] quieted
);
   logic exp_full;
   logic frac_nz;

   always_comb begin
      exp_full = &x[W-2:MAN_W];
      frac_nz  = |x[MAN_W-1:0];
      is_nan   = exp_full && frac_nz;
      quieted  = x;
      quieted[MAN_W-1] = 1'b1;
   end
endmodule

// File: rtl/minmax_order.sv
module minmax_order #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         use_mag,
   output logic         a_lt_b,
   output logic         b_lt_a
);
   logic [W-1:0] key_a, key_b;
   logic         s_lt, s_gt, m_lt, m_gt, m_eq;

   always_comb begin
      // Monotonic keys: negative values invert, positive values gain the top bit.
      key_a = a[W-1] ? ~a : {1'b1, a[W-2:0]};
      key_b = b[W-1] ? ~b : {1'b1, b[W-2:0]};
      s_lt  = key_a < key_b;
      s_gt  = key_b < key_a;
      m_lt  = a[W-2:0] < b[W-2:0];
      m_gt  = b[W-2:0] < a[W-2:0];
      m_eq  = a[W-2:0] == b[W-2:0];
      if (use_mag) begin
         a_lt_b = m_lt || (m_eq && s_lt);
         b_lt_a = m_gt || (m_eq && s_gt);
      end else begin
         a_lt_b = s_lt;
         b_lt_a = s_gt;
      end
   end
endmodule

// File: rtl/minmax_pick.sv
module minmax_pick
   import minmax_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] a_quiet,
   input  logic [W-1:0] b_quiet,
   input  logic         a_nan,
   input  logic         b_nan,
   input  logic         a_lt_b,
   input  logic         b_lt_a,
   input  op_sel_t      op,
   input  sign_pol_e    pol,
   output logic [W-1:0] res
);
   logic [W-1:0] chosen;
   logic         take_a;

   always_comb begin
      take_a = op.is_max ? !a_lt_b : !b_lt_a;
      if (op.num_form) begin
         if (a_nan && b_nan)  chosen = a_quiet;
         else if (a_nan)      chosen = b;
         else if (b_nan)      chosen = a;
         else                 chosen = take_a ? a : b;
      end else begin
         if (a_nan)           chosen = a_quiet;
         else if (b_nan)      chosen = b_quiet;
         else                 chosen = take_a ? a : b;
      end
      res = chosen;
      unique case (pol)
         SGN_FROM_A: res[W-1] = a[W-1];
         SGN_KEEP:   res[W-1] = chosen[W-1];
         SGN_CLEAR:  res[W-1] = 1'b0;
         SGN_SET:    res[W-1] = 1'b1;
         default:    res[W-1] = chosen[W-1];
      endcase
   end
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
   import minmax_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int MAN_W   = 23,
   parameter bit REG_OUT = 1'b1,
   localparam int W = 1 + EXP_W + MAN_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic [7:0]   ctrl_imm,
   output logic         out_valid,
   output logic [W-1:0] result
);
   initial begin
      assert (EXP_W >= 2) else $error("EXP_W must be at least 2");
      assert (MAN_W >= 2) else $error("MAN_W must be at least 2");
   end

   logic [W-1:0] opnd     [2];
   logic [W-1:0] opnd_q   [2];
   logic         opnd_nan [2];
   logic         a_lt_b, b_lt_a;
   logic [W-1:0] sel_res;
   op_sel_t      op;
   sign_pol_e    pol;
   logic         unused_ctrl;

   assign opnd[0]     = op_a;
   assign opnd[1]     = op_b;
   assign op          = op_sel_t'(ctrl_imm[2:0]);
   assign pol         = sign_pol_e'(ctrl_imm[4:3]);
   assign unused_ctrl = ^ctrl_imm[7:5];

   for (genvar i = 0; i < 2; i++) begin : g_cls
      minmax_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
         .x       (opnd[i]),
         .is_nan  (opnd_nan[i]),
         .quieted (opnd_q[i])
      );
   end

   minmax_order #(.W(W)) u_order (
      .a       (op_a),
      .b       (op_b),
      .use_mag (op.use_mag),
      .a_lt_b  (a_lt_b),
      .b_lt_a  (b_lt_a)
   );

   minmax_pick #(.W(W)) u_pick (
      .a       (op_a),
      .b       (op_b),
      .a_quiet (opnd_q[0]),
      .b_quiet (opnd_q[1]),
      .a_nan   (opnd_nan[0]),
      .b_nan   (opnd_nan[1]),
      .a_lt_b  (a_lt_b),
      .b_lt_a  (b_lt_a),
      .op      (op),
      .pol     (pol),
      .res     (sel_res)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) result <= sel_res;
         end
      end

      // R8: valid travels with a one-cycle latency
      a_r8_valid_pipe: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      a_r8_valid_low: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!out_valid && $stable(result)));
      // R4: any NaN on the output is quiet
      a_r4_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && (&result[W-2:MAN_W]) && (|result[MAN_W-1:0]))
         |-> result[MAN_W-1]);
      // R2: forced sign policies
      a_r2_sign_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && ctrl_imm[4:3] == 2'b10) |=> !result[W-1]);
      a_r2_sign_set: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && ctrl_imm[4:3] == 2'b11) |=> result[W-1]);
      // R5: a single NaN yields to the other operand in number forms
      a_r5_num_yield: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && ctrl_imm[2] && (opnd_nan[0] != opnd_nan[1]))
         |=> (result[W-2:0] == ($past(opnd_nan[0]) ? $past(op_b[W-2:0])
                                                   : $past(op_a[W-2:0]))));
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign out_valid  = in_valid;
      assign result     = sel_res;
   end
endmodule

// File: tb/fp_minmax_unit_bench.sv
`timescale 1ns/1ps
module fp_minmax_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] op_a = '0, op_b = '0;
   logic [7:0]  ctrl_imm = '0;
   logic        out_valid;
   logic [31:0] result;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   fp_minmax_unit u_fp_minmax_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .op_a(op_a), .op_b(op_b), .ctrl_imm(ctrl_imm),
      .out_valid(out_valid), .result(result)
   );

   logic [31:0] vals [13];
   initial begin
      vals[0]  = 32'h0000_0000; vals[1]  = 32'h8000_0000;
      vals[2]  = 32'h3F80_0000; vals[3]  = 32'hBF80_0000;
      vals[4]  = 32'h3FC0_0000; vals[5]  = 32'hBFC0_0000;
      vals[6]  = 32'h7F80_0000; vals[7]  = 32'hFF80_0000;
      vals[8]  = 32'h7FC0_0001; vals[9]  = 32'h7F80_0005;
      vals[10] = 32'hFFA0_0000; vals[11] = 32'h0000_0003;
      vals[12] = 32'h7F7F_FFFF;
   end

   function automatic bit is_nan(input logic [31:0] x);
      return (x[30:23] == 8'hFF) && (x[22:0] != 0);
   endfunction

   function automatic real to_real(input logic [31:0] x);
      real m;
      int  e;
      e = int'(x[30:23]);
      if (e == 255) m = 1.0e300;
      else if (e == 0) m = real'(x[22:0]) * (2.0 ** -149);
      else m = (1.0 + real'(x[22:0]) / 8388608.0) * (2.0 ** (e - 127));
      return x[31] ? -m : m;
   endfunction

   // strict "x orders below y"
   function automatic bit ref_lt(input logic [31:0] x, input logic [31:0] y, input bit mag);
      real vx, vy;
      vx = to_real(x); vy = to_real(y);
      if (mag) begin
         if (vx < 0.0) vx = -vx;
         if (vy < 0.0) vy = -vy;
      end
      if (vx < vy) return 1'b1;
      if (vx > vy) return 1'b0;
      return x[31] && !y[31];
   endfunction

   function automatic logic [31:0] ref_model(input logic [31:0] a, input logic [31:0] b,
                                             input logic [7:0] c);
      logic [31:0] r;
      bit mx, mg, nm, an, bn;
      mx = c[0]; mg = c[1]; nm = c[2];
      an = is_nan(a); bn = is_nan(b);
      if (nm && an && bn)      r = a | 32'h0040_0000;
      else if (nm && an)       r = b;
      else if (nm && bn)       r = a;
      else if (an)             r = a | 32'h0040_0000;
      else if (bn)             r = b | 32'h0040_0000;
      else if (mx)             r = ref_lt(a, b, mg) ? b : a;
      else                     r = ref_lt(b, a, mg) ? b : a;
      case (c[4:3])
         2'b00: r[31] = a[31];
         2'b10: r[31] = 1'b0;
         2'b11: r[31] = 1'b1;
         default: ;
      endcase
      return r;
   endfunction

   function automatic string tag_of(input logic [31:0] a, input logic [31:0] b,
                                    input logic [7:0] c);
      string t;
      if (c[2] && (is_nan(a) || is_nan(b)))  t = "R5";
      else if (is_nan(a) || is_nan(b))       t = "R4";
      else if (a[30:0] == 0 && b[30:0] == 0) t = "R3";
      else if (a[30:23] == 8'hFF || b[30:23] == 8'hFF) t = "R10";
      else if (a == b)                       t = "R7";
      else if (c[1])                         t = "R6";
      else                                   t = "R1";
      if (c[4:3] != 2'b01) t = {t, "/R2"};
      if (c[7:5] != 0)     t = {t, "/R9"};
      return t;
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [7:0] c);
      @(negedge clk);
      op_a = a; op_b = b; ctrl_imm = c; in_valid = 1'b1;
      @(posedge clk);
      #1;
      check(tag_of(a, b, c), result, ref_model(a, b, c));
      check("R8 valid", {31'd0, out_valid}, 32'd1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] held;
      repeat (3) @(posedge clk);
      #1;
      check("R8 reset valid", {31'd0, out_valid}, 32'd0);
      check("R8 reset result", result, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < 13; i++)
         for (int j = 0; j < 13; j++)
            for (int c = 0; c < 32; c++)
               apply(vals[i], vals[j], 8'(c));

      // R9: upper control bits ignored
      for (int i = 0; i < 13; i++)
         for (int c = 0; c < 32; c++)
            apply(vals[i], vals[(i + 5) % 13], 8'(c) | 8'(((i % 7) + 1) << 5));

      // R3 explicit, both orders
      apply(32'h0000_0000, 32'h8000_0000, 8'h08);
      check("R3 min +0,-0", result, 32'h8000_0000);
      apply(32'h8000_0000, 32'h0000_0000, 8'h09);
      check("R3 max -0,+0", result, 32'h0000_0000);
      // R6 opposite-sign magnitude tie
      apply(32'h3F80_0000, 32'hBF80_0000, 8'h0A);
      check("R6 minmag tie", result, 32'hBF80_0000);

      // R8: valid low holds result and drops out_valid
      apply(32'h3F80_0000, 32'h3FC0_0000, 8'h09);
      held = result;
      @(negedge clk);
      in_valid = 1'b0; op_a = 32'h7F80_0000; op_b = 32'hFF80_0000;
      @(posedge clk);
      #1;
      check("R8 idle valid", {31'd0, out_valid}, 32'd0);
      check("R8 idle hold", result, held);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule